// File: doc/BRIEF.md
# Dual-Group Programmable Digital I/O Controller

The block gives a host a register-mapped view of a set of parallel digital I/O lines. The lines are organised in identical groups (two by default). Each group has three 8-bit ports, A, B and C. Port C is split into two nibbles. That makes four direction sections per group: A, B, C-lower and C-upper. Each section can be an input or an output.

One control word per group sets all four directions. Each group has three output data registers and drives one output enable per section. A read of a port returns the live pin value on input bits and the stored data on output bits.

An external latch input per group passes through a synchronizer. On its rising edge, the group freezes the current value of all three ports into snapshot registers. The host can read those snapshots later.

All directions default to input on every reset:
- on the asynchronous hardware reset;
- on a write-only software reset strobe, one per group.

Output data registers keep their contents across a software reset. They also accept writes while their section is an input. As a result, a safe value can be loaded before a section is turned into an output, and it reaches the pins the moment the direction changes.

Register offsets within a group (the low three address bits; the bits above them select the group):
- 0: port A data
- 1: port B data
- 2: port C data
- 3: control word
- 4: snapshot A
- 5: snapshot B
- 6: snapshot C
- 7: software reset (write-only)

Top module: `dio_port_groups`

## Requirements
- R1: After the asynchronous reset, every group's control word reads 0x1B and every section output enable is 0 (all inputs). Every snapshot register reads 0.
- R2: Control word bit mapping, where a 1 makes the section an input and a 0 makes it an output:
  - bit 4 sets port A;
  - bit 3 sets the C upper nibble;
  - bit 1 sets port B;
  - bit 0 sets the C lower nibble.

  The enable output `sec_oe_o[4*g +: 4]` of group g is ordered {C-upper, C-lower, B, A} from bit 3 down to bit 0. It changes only on a control word write or a software reset.
- R3: Control word bits 2, 5, 6 and 7 are ignored on write and read back as 0. For example, writing 0xFF reads back 0x1B, and writing 0x04 reads back 0x00.
- R4: Writes to port data registers (offsets 0 to 2) are stored whatever the direction. The stored value is always present on `pin_o`. When a section becomes an output, its enable rises in the cycle after the control write, with the earlier data already on the pins and not cleared.
- R5: A port read returns the data register on output bits and `pin_i` on input bits, merged per nibble for port C. `rdata_o` reflects the address presented in the previous cycle.
- R6: A write of any value to offset 7 resets that group's control word to 0x1B. Output data registers and the other groups are unchanged.
- R7: Each latch input passes through a 2-flop synchronizer. On each rising edge, the group's snapshot registers (offsets 4, 5 and 6) capture the current read value of ports A, B and C. Snapshots do not change while the latch is held high or low.
- R8: Groups are independent. A write to one group never alters another group's control word, enables, data or snapshots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address: group select bits above a 3-bit offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data for the previous cycle's address |
| pin_i | input | 48 | Pin levels; group g occupies bits 24g+ : A[7:0], B[15:8], C[23:16] |
| pin_o | output | 48 | Output data register values, same layout as pin_i |
| sec_oe_o | output | 8 | Section output enables; per group {C-upper, C-lower, B, A} |
| latch_i | input | 2 | Asynchronous snapshot latch, one per group |

## Verification
Register writes and the software reset take effect at the clock edge that samples them. The bench therefore checks enables and pin data on the falling edge after the write's rising edge. Read data is due one edge after the address is applied: the driver presents an address on a falling edge and queues the expected word, and the monitor compares it just after the next rising edge. Snapshot capture needs three rising edges after the latch rises (two synchronizer flops and the capture edge). The bench holds the latch and waits several cycles before reading the snapshots. It then changes the pins while the latch stays high, to show that the capture happens on the edge only.

// File: rtl/dio_pkg.sv
package dio_pkg;
  localparam int unsigned REG_OFS_W = 3;

  typedef enum logic [REG_OFS_W-1:0] {
    OFS_PA     = 3'd0,
    OFS_PB     = 3'd1,
    OFS_PC     = 3'd2,
    OFS_CTRL   = 3'd3,
    OFS_SNAP_A = 3'd4,
    OFS_SNAP_B = 3'd5,
    OFS_SNAP_C = 3'd6,
    OFS_SWRST  = 3'd7
  } reg_ofs_e;

  localparam logic [7:0] CTRL_DEFAULT = 8'h1B;
  localparam logic [7:0] CTRL_MASK    = 8'h1B;

  // control word bit positions (1 = input)
  localparam int unsigned CB_CL = 0;
  localparam int unsigned CB_B  = 1;
  localparam int unsigned CB_CU = 3;
  localparam int unsigned CB_A  = 4;

  // section enable index
  localparam int unsigned SEC_A  = 0;
  localparam int unsigned SEC_B  = 1;
  localparam int unsigned SEC_CL = 2;
  localparam int unsigned SEC_CU = 3;
  localparam int unsigned NUM_SEC = 4;
  localparam int unsigned NUM_PORTS = 3;
endpackage

// File: rtl/dio_latch_sync.sv
module dio_latch_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R7: capture strobe lasts one cycle per edge
  a_r7_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/dio_group.sv
module dio_group
  import dio_pkg::*;
#(
  parameter  int unsigned PORT_W = 8,
  parameter  int unsigned SYNC_STAGES = 2,
  localparam int unsigned NIB_W  = PORT_W / 2,
  localparam int unsigned PINS_W = NUM_PORTS * PORT_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [REG_OFS_W-1:0] ofs_i,
  input  logic [PORT_W-1:0]    wdata_i,
  input  logic [PINS_W-1:0]    pin_i,
  output logic [PINS_W-1:0]    pin_o,
  output logic [NUM_SEC-1:0]   sec_oe_o,
  input  logic                 latch_i,
  output logic [PORT_W-1:0]    rdata_o
);
  localparam logic [PORT_W-1:0] CTRL_RST = PORT_W'(CTRL_DEFAULT);
  localparam logic [PORT_W-1:0] CTRL_MSK = PORT_W'(CTRL_MASK);

  logic [PORT_W-1:0]                   ctrl_q;
  logic [NUM_PORTS-1:0][PORT_W-1:0]    data_q;
  logic [NUM_PORTS-1:0][PORT_W-1:0]    snap_q;
  logic [NUM_PORTS-1:0][PORT_W-1:0]    view;
  logic [PINS_W-1:0]                   bit_oe;
  logic                                cap;
  logic                                ctrl_wr, swrst;

  assign ctrl_wr = wr_i && (ofs_i == OFS_CTRL);
  assign swrst   = wr_i && (ofs_i == OFS_SWRST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= CTRL_RST;
    else if (swrst)   ctrl_q <= CTRL_RST;
    else if (ctrl_wr) ctrl_q <= wdata_i & CTRL_MSK;
  end

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_data
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                  data_q[p] <= '0;
        else if (wr_i && (ofs_i == REG_OFS_W'(p)))    data_q[p] <= wdata_i;
      end
    end
  endgenerate

  assign sec_oe_o[SEC_A]  = ~ctrl_q[CB_A];
  assign sec_oe_o[SEC_B]  = ~ctrl_q[CB_B];
  assign sec_oe_o[SEC_CL] = ~ctrl_q[CB_CL];
  assign sec_oe_o[SEC_CU] = ~ctrl_q[CB_CU];

  assign bit_oe = {{NIB_W{sec_oe_o[SEC_CU]}}, {NIB_W{sec_oe_o[SEC_CL]}},
                   {PORT_W{sec_oe_o[SEC_B]}}, {PORT_W{sec_oe_o[SEC_A]}}};

  assign pin_o = data_q;
  assign view  = (pin_o & bit_oe) | (pin_i & ~bit_oe);

  dio_latch_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(latch_i),
    .rise_o (cap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  snap_q <= '0;
    else if (cap) snap_q <= view;
  end

  always_comb begin
    unique case (ofs_i)
      OFS_PA:     rdata_o = view[0];
      OFS_PB:     rdata_o = view[1];
      OFS_PC:     rdata_o = view[2];
      OFS_CTRL:   rdata_o = ctrl_q;
      OFS_SNAP_A: rdata_o = snap_q[0];
      OFS_SNAP_B: rdata_o = snap_q[1];
      OFS_SNAP_C: rdata_o = snap_q[2];
      default:    rdata_o = '0;
    endcase
  end

  // R4, R6: data only changes on its own write; software reset keeps it
  a_r4_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && (ofs_i < REG_OFS_W'(NUM_PORTS))) |=> $stable(data_q));
  a_r6_swrst_default: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst |=> (sec_oe_o == '0));
  a_r2_oe_only_on_ctrl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_wr || swrst) |=> $stable(sec_oe_o));
  a_r7_snap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap |=> $stable(snap_q));
endmodule

// File: rtl/dio_port_groups.sv
module dio_port_groups
  import dio_pkg::*;
#(
  parameter  int unsigned NUM_GROUPS  = 2,
  parameter  int unsigned PORT_W      = 8,
  parameter  int unsigned SYNC_STAGES = 2,
  localparam int unsigned GRP_W  = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int unsigned ADDR_W = GRP_W + REG_OFS_W,
  localparam int unsigned GPIN_W = NUM_PORTS * PORT_W,
  localparam int unsigned PIN_W  = NUM_GROUPS * GPIN_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [PORT_W-1:0]             wdata_i,
  output logic [PORT_W-1:0]             rdata_o,
  input  logic [PIN_W-1:0]              pin_i,
  output logic [PIN_W-1:0]              pin_o,
  output logic [NUM_GROUPS*NUM_SEC-1:0] sec_oe_o,
  input  logic [NUM_GROUPS-1:0]         latch_i
);
  logic [REG_OFS_W-1:0]               ofs;
  logic [GRP_W-1:0]                   grp;
  logic [NUM_GROUPS-1:0][PORT_W-1:0]  grp_rd;
  logic [PORT_W-1:0]                  rd_sel;

  assign ofs = addr_i[REG_OFS_W-1:0];
  assign grp = addr_i[ADDR_W-1:REG_OFS_W];

  generate
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      dio_group #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) u_grp (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (wr_i && (grp == GRP_W'(g))),
        .ofs_i   (ofs),
        .wdata_i (wdata_i),
        .pin_i   (pin_i[g*GPIN_W +: GPIN_W]),
        .pin_o   (pin_o[g*GPIN_W +: GPIN_W]),
        .sec_oe_o(sec_oe_o[g*NUM_SEC +: NUM_SEC]),
        .latch_i (latch_i[g]),
        .rdata_o (grp_rd[g])
      );
    end
  endgenerate

  always_comb begin
    rd_sel = '0;
    for (int g = 0; g < NUM_GROUPS; g++)
      if (grp == GRP_W'(g)) rd_sel = grp_rd[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_sel;
  end

  // R3: reserved control bits never seen on a read
  a_r3_ctrl_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ofs == OFS_CTRL) |=> ((rdata_o & ~PORT_W'(CTRL_MASK)) == '0));
endmodule

// File: tb/dio_port_groups_tb.sv
module dio_port_groups_tb;
  localparam int unsigned NG = 2;
  localparam int unsigned PW = 8;
  localparam int unsigned AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [PW-1:0] wdata = '0;
  logic [PW-1:0] rdata;
  logic [47:0]   pin_in = '0;
  logic [47:0]   pin_out;
  logic [7:0]    oe;
  logic [NG-1:0] latch = '0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  dio_port_groups u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin_in), .pin_o(pin_out), .sec_oe_o(oe),
    .latch_i(latch)
  );

  // monitor: each queued read is due one rising edge after its address
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_cmp++;
      if (rdata !== it.exp) begin
        n_bad++;
        $display("FAIL %s: rdata actual %h expected %h", it.tag, rdata, it.exp);
      end
    end
  end

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    wr = 1'b0;
    addr = a;
    q.push_back('{exp: e, tag: tag});
  endtask

  task automatic wrr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic chk(input logic [47:0] act, input logic [47:0] e, input string tag);
    n_cmp++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, e);
    end
  endtask

  task automatic drain();
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(48'(oe), 48'h0, "R1 oe after reset");
    rd(4'h3, 8'h1B, "R1 ctrl g0 reset");
    rd(4'hB, 8'h1B, "R1 ctrl g1 reset");
    rd(4'hC, 8'h00, "R1 snap g1 reset");
    drain();

    // R4 write data while input; R5 input read returns pins
    pin_in[23:0] = 24'h00_00_3C;
    wrr(4'h0, 8'hA5);
    chk(48'(oe), 48'h0, "R4 oe still off after data write");
    chk(48'(pin_out[7:0]), 48'hA5, "R4 data stored while input");
    rd(4'h0, 8'h3C, "R5 port A input read");
    drain();

    // R2/R4: port A to output, old data at once
    wrr(4'h3, 8'h0B);
    chk(48'(oe[3:0]), 48'h1, "R2 ctrl 0B enables A only");
    chk(48'(pin_out[7:0]), 48'hA5, "R4 data on pins when output");
    rd(4'h0, 8'hA5, "R5 port A output read");
    drain();

    // R3 reserved bits
    wrr(4'h3, 8'hFF);
    rd(4'h3, 8'h1B, "R3 write FF reads 1B");
    drain();
    wrr(4'h3, 8'h04);
    rd(4'h3, 8'h00, "R3 write 04 reads 00");
    drain();
    chk(48'(oe[3:0]), 48'hF, "R2 ctrl 04 all outputs");

    // R2/R5 port C nibbles
    pin_in[23:16] = 8'hC3;
    wrr(4'h2, 8'h5A);
    wrr(4'h3, 8'h01);
    chk(48'(oe[3:0]), 48'hB, "R2 ctrl 01 C lower input");
    rd(4'h2, 8'h53, "R5 port C lower from pins");
    drain();
    wrr(4'h3, 8'h08);
    chk(48'(oe[3:0]), 48'h7, "R2 ctrl 08 C upper input");
    rd(4'h2, 8'hCA, "R5 port C upper from pins");
    drain();
    wrr(4'h3, 8'h02);
    chk(48'(oe[3:0]), 48'hD, "R2 ctrl 02 B input");

    // R8 independence
    chk(48'(oe[7:4]), 48'h0, "R8 g1 untouched");
    wrr(4'hB, 8'h10);
    chk(48'(oe[7:4]), 48'hE, "R8 g1 ctrl 10");
    chk(48'(oe[3:0]), 48'hD, "R8 g0 unchanged by g1 write");

    // R6 software reset
    wrr(4'h7, 8'h00);
    chk(48'(oe[3:0]), 48'h0, "R6 swrst g0 all inputs");
    chk(48'(pin_out[23:0]), 48'h5A_00_A5, "R6 data kept by swrst");
    rd(4'h3, 8'h1B, "R6 ctrl g0 after swrst");
    rd(4'hB, 8'h10, "R8 g1 ctrl kept on g0 swrst");
    drain();
    wrr(4'h3, 8'h00);
    rd(4'h0, 8'hA5, "R6 port A data retained");
    drain();

    // R7 snapshot
    wrr(4'h3, 8'h1B);
    pin_in[23:0] = 24'h77_66_55;
    @(negedge clk);
    latch[0] = 1'b1;
    repeat (6) @(negedge clk);
    pin_in[23:0] = 24'h11_22_33;
    repeat (4) @(negedge clk);
    rd(4'h4, 8'h55, "R7 snap A");
    rd(4'h5, 8'h66, "R7 snap B");
    rd(4'h6, 8'h77, "R7 snap C held while latch high");
    rd(4'hC, 8'h00, "R8 g1 snap unaffected");
    drain();
    latch[0] = 1'b0;
    repeat (5) @(negedge clk);
    rd(4'h4, 8'h55, "R7 no capture on falling latch");
    drain();
    latch[0] = 1'b1;
    repeat (6) @(negedge clk);
    rd(4'h4, 8'h33, "R7 recapture A");
    rd(4'h6, 8'h11, "R7 recapture C");
    drain();
    drain();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule